// File: doc/BRIEF.md
# LCD Frame-Refresh DMA Sequencer

This block repeatedly reads a packed-pixel frame buffer out of memory and streams it, word by word, to an LCD panel interface. Software programs a start word address, an end word address, a pixel depth code, a split-panel flag, a words-per-line value and a lines-per-frame value. It then raises the enable input. The block issues sequential single-word read requests on a request/acknowledge port. Each returned word is forwarded to the panel with a data strobe. The block marks the last word of every line and of every frame, and it flips a panel AC-bias output once per frame.

The horizontal value holds the number of words per line minus one. The line value holds the number of line fetches per panel half minus one. A split panel is refreshed as two halves, so a split frame has twice as many line fetches, and a half indicator tells the panel which half each word belongs to. A freeze request does not stop the refresh at once. It takes effect when the current frame ends. Refresh starts again only after enable is dropped and then raised with freeze clear, so the address counter lines up with a fresh frame.

Top module: `lcd_refresh_dma`

## Requirements
- R1: While enable is low, and from the cycle after it falls, mem_req, data_valid, line_strobe, frame_strobe and ac_bias are 0 and idle is 1; this is also the state after reset.
- R2: When enable rises from idle with freeze low, the first request addresses start_addr, and each acknowledged request advances the address by one word.
- R3: An unacknowledged request stays asserted with an unchanged address while enable stays high.
- R4: One cycle after a request is acknowledged, data_valid is 1 for one cycle and pix_data carries the acknowledged word.
- R5: line_strobe is 1 together with data_valid for the word that completes a line, which is every (hcount+1)-th word.
- R6: A frame is (lcount+1) lines without split and 2*(lcount+1) lines with split; frame_strobe marks its last word, and the next request addresses start_addr.
- R7: lower_half is 0 for the first lcount+1 lines of a split frame and 1 for the rest; without split it is always 0.
- R8: If the next address would equal end_addr before the frame ends, the address reloads to start_addr without a frame_strobe, so requests stay in [start_addr, end_addr).
- R9: ac_bias inverts with every frame_strobe and is 0 after leaving idle.
- R10: Raising freeze lets the current frame finish; after its frame_strobe no request is issued and idle is 1 until enable is dropped, after which a restart begins again at start_addr.
- R11: pix_per_word equals the data width shifted right by the depth code, where the codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel (32, 16, 8 and 4 pixels for a 32-bit word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the refresh; low forces idle |
| freeze | input | 1 | Stop at the end of the current frame |
| depth | input | 2 | Pixel depth code, bits per pixel = 1 << code |
| split | input | 1 | Panel refreshed as two halves |
| start_addr | input | AW | First word address of the buffer |
| end_addr | input | AW | Word address one past the buffer |
| hcount | input | HW | Words per line minus one |
| lcount | input | LW | Lines per panel half minus one |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read word address |
| mem_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata | input | DW | Read data |
| frame_strobe | output | 1 | Last word of a frame |
| line_strobe | output | 1 | Last word of a line |
| data_valid | output | 1 | pix_data holds a new word |
| pix_data | output | DW | Word sent to the panel |
| lower_half | output | 1 | Word belongs to the lower panel half |
| ac_bias | output | 1 | Panel AC-bias, inverted every frame |
| pix_per_word | output | $clog2(DW)+1 | Pixels packed in one word |
| idle | output | 1 | No refresh in progress |

## Verification
The assertions assume that the memory raises mem_ack only while mem_req is high. They assume that every configuration input is held steady while enable is high. They also assume that end_addr is above start_addr. The bench changes configuration only when enable has been low for several cycles, and its memory model acknowledges only a pending request. Before dropping enable, the bench first stops acknowledging, so no word is in flight when the block goes idle. Random configurations always pick an end address at least one word above the start.

// File: rtl/lcd_refresh_dma.sv
module lcd_refresh_dma #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int HW = 8,
  parameter int LW = 10,
  localparam int PW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          freeze,
  input  logic [1:0]    depth,
  input  logic          split,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic [HW-1:0] hcount,
  input  logic [LW-1:0] lcount,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          frame_strobe,
  output logic          line_strobe,
  output logic          data_valid,
  output logic [DW-1:0] pix_data,
  output logic          lower_half,
  output logic          ac_bias,
  output logic [PW-1:0] pix_per_word,
  output logic          idle
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FROZEN} state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [HW-1:0] wcnt;
  logic [LW-1:0] lcnt;
  logic          half;

  wire [AW-1:0] addr_nx   = addr + 1'b1;
  wire          eol       = (wcnt == hcount);
  wire          last_line = (lcnt == lcount);
  wire          eof       = eol && last_line && (!split || half);

  assign mem_req      = (state == S_RUN);
  assign mem_addr     = addr;
  assign idle         = (state != S_RUN);
  assign pix_per_word = PW'(DW >> depth);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      addr         <= '0;
      wcnt         <= '0;
      lcnt         <= '0;
      half         <= 1'b0;
      data_valid   <= 1'b0;
      line_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
      pix_data     <= '0;
      lower_half   <= 1'b0;
      ac_bias      <= 1'b0;
    end else begin
      data_valid   <= 1'b0;
      line_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
      if (!enable) begin
        state      <= S_IDLE;
        ac_bias    <= 1'b0;
        lower_half <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (!freeze) begin
            state <= S_RUN;
            addr  <= start_addr;
            wcnt  <= '0;
            lcnt  <= '0;
            half  <= 1'b0;
          end
          S_RUN: if (mem_ack) begin
            data_valid   <= 1'b1;
            pix_data     <= mem_rdata;
            line_strobe  <= eol;
            frame_strobe <= eof;
            lower_half   <= half;
            addr         <= (eof || addr_nx == end_addr) ? start_addr : addr_nx;
            wcnt         <= eol ? '0 : wcnt + 1'b1;
            if (eol) lcnt <= last_line ? '0 : lcnt + 1'b1;
            if (eol && last_line) half <= split & ~half;
            if (eof) ac_bias <= ~ac_bias;
            if (eof && freeze) state <= S_FROZEN;
          end
          default: ;
        endcase
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mem_req && !data_valid && !ac_bias && idle));

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && enable) |=> (mem_req && $stable(mem_addr)));

  assert_frame_is_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (line_strobe && data_valid));

  assert_addr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= start_addr && mem_addr < end_addr));

  assert_bias_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (ac_bias != $past(ac_bias)));

  assert_freeze_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && $past(freeze)) |-> (!mem_req && idle));

endmodule

// File: tb/lcd_refresh_dma_bench.sv
module lcd_refresh_dma_bench;
  localparam int AW = 16, DW = 32, HW = 8, LW = 10, PW = $clog2(DW) + 1;

  logic clk = 0, rst_n = 0;
  logic enable = 0, freeze = 0, split = 0;
  logic [1:0] depth = 0;
  logic [AW-1:0] start_addr = 0, end_addr = 1;
  logic [HW-1:0] hcount = 0;
  logic [LW-1:0] lcount = 0;
  logic mem_req, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = 0;
  logic frame_strobe, line_strobe, data_valid, lower_half, ac_bias, idle;
  logic [DW-1:0] pix_data;
  logic [PW-1:0] pix_per_word;

  lcd_refresh_dma #(.AW(AW), .DW(DW), .HW(HW), .LW(LW)) u_lcd_refresh_dma (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freeze(freeze), .depth(depth),
    .split(split), .start_addr(start_addr), .end_addr(end_addr), .hcount(hcount),
    .lcount(lcount), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .frame_strobe(frame_strobe), .line_strobe(line_strobe),
    .data_valid(data_valid), .pix_data(pix_data), .lower_half(lower_half),
    .ac_bias(ac_bias), .pix_per_word(pix_per_word), .idle(idle));

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int frames_seen = 0, beats_seen = 0, wait_cnt = 0;
  bit hold_mem = 1, pend = 0, prev_noack = 0, saw_frame = 0, done = 0;
  logic [AW-1:0] prev_addr, m_addr;
  logic [HW-1:0] m_w;
  logic [LW-1:0] m_l;
  bit m_half, m_bias;
  logic [DW-1:0] e_data;
  bit e_line, e_frame, e_half;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_addr = start_addr; m_w = 0; m_l = 0; m_half = 0; m_bias = 0;
  endtask

  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (pend) begin
        check(data_valid == 1 && pix_data == e_data, "R4", pix_data, e_data);
        check(line_strobe == e_line, "R5", line_strobe, e_line);
        check(frame_strobe == e_frame, "R6", frame_strobe, e_frame);
        check(lower_half == e_half, "R7", lower_half, e_half);
        if (e_frame) check(ac_bias == m_bias, "R9", ac_bias, m_bias);
        beats_seen++;
        if (frame_strobe) begin frames_seen++; saw_frame = 1; end
      end else if (data_valid) begin
        check(0, "R4", data_valid, 0);
      end
      pend = 0;
      if (prev_noack && enable)
        check(mem_req && mem_addr == prev_addr, "R3", mem_addr, prev_addr);
      mem_ack = 0;
      prev_noack = 0;
      if (mem_req && !hold_mem && wait_cnt == 0) begin
        bit eol, eof;
        logic [AW-1:0] nx;
        check(mem_addr == m_addr, "R2/R6/R8 address", mem_addr, m_addr);
        mem_ack = 1;
        mem_rdata = word_of(mem_addr);
        eol = (m_w == hcount);
        eof = eol && (m_l == lcount) && (!split || m_half);
        e_data = mem_rdata; e_line = eol; e_frame = eof; e_half = m_half;
        nx = m_addr + 1'b1;
        m_addr = (eof || nx == end_addr) ? start_addr : nx;
        if (eol) begin
          if (m_l == lcount) begin m_l = 0; m_half = split & ~m_half; end
          else m_l = m_l + 1'b1;
          m_w = 0;
        end else m_w = m_w + 1'b1;
        if (eof) m_bias = ~m_bias;
        pend = 1;
        wait_cnt = $urandom_range(0, 2);
      end else begin
        if (mem_req) begin prev_noack = 1; prev_addr = mem_addr; end
        if (wait_cnt > 0) wait_cnt--;
      end
    end
  end

  task automatic quiet_check(input string req);
    check(!mem_req && !data_valid && !line_strobe && !frame_strobe, req, mem_req, 0);
    check(!ac_bias && idle, req, {ac_bias, idle}, 2'b01);
  endtask

  task automatic stop_run();
    @(negedge clk); #1 hold_mem = 1;
    repeat (4) @(negedge clk);
    #1 enable = 0;
    repeat (3) @(negedge clk);
    quiet_check("R1");
  endtask

  task automatic run_cfg(input logic [AW-1:0] st, input logic [AW-1:0] en,
                         input int hc, input int lc, input bit sp,
                         input int nf, input int nb);
    @(negedge clk); #1;
    start_addr = st; end_addr = en; hcount = HW'(hc); lcount = LW'(lc); split = sp;
    frames_seen = 0; beats_seen = 0;
    model_reset();
    hold_mem = 0; enable = 1;
    while (frames_seen < nf || beats_seen < nb) @(negedge clk);
    stop_run();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    quiet_check("R1 reset");
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    quiet_check("R1 after reset");

    for (int d = 0; d < 4; d++) begin
      #1 depth = 2'(d);
      @(negedge clk);
      check(pix_per_word == PW'(DW >> d), "R11", pix_per_word, DW >> d);
    end

    run_cfg(16'h0100, 16'h010C, 3, 2, 0, 3, 0);
    run_cfg(16'h0200, 16'h0208, 1, 1, 1, 3, 0);
    run_cfg(16'h0300, 16'h0305, 3, 3, 0, 2, 0);
    run_cfg(16'h0400, 16'h0440, 7, 7, 0, 0, 5);

    for (int i = 0; i < 20; i++) begin
      int hc, lc, words;
      bit sp;
      logic [AW-1:0] st, en;
      hc = $urandom_range(0, 5); lc = $urandom_range(0, 3); sp = 1'($urandom_range(0, 1));
      words = (hc + 1) * (lc + 1) * (sp ? 2 : 1);
      st = AW'($urandom_range(16, 1000));
      en = ($urandom_range(0, 3) == 0) ? st + AW'($urandom_range(1, words)) : st + AW'(words);
      run_cfg(st, en, hc, lc, sp, $urandom_range(1, 3), 0);
    end

    @(negedge clk); #1;
    start_addr = 16'h0500; end_addr = 16'h0506; hcount = 2; lcount = 1; split = 0;
    frames_seen = 0; beats_seen = 0; model_reset();
    hold_mem = 0; enable = 1;
    while (frames_seen < 1) @(negedge clk);
    #1 freeze = 1; saw_frame = 0;
    while (!saw_frame) @(negedge clk);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check(!mem_req && idle && !data_valid, "R10 frozen", mem_req, 0);
    end
    #1 hold_mem = 1; enable = 0;
    repeat (3) @(negedge clk);
    #1 freeze = 0;
    run_cfg(16'h0500, 16'h0506, 2, 1, 0, 2, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule